// File: doc/BRIEF.md
# Interrupt Enable and Arbitration Unit

This unit sits beside a small microcontroller core and decides when the core must take an interrupt. Every source has a sticky event flag and an enable bit. Sources fall into a core group and a peripheral group, and the peripheral group has a group enable of its own. Above the sources sit two global gates. The first is a software-visible global enable bit. The second is an internal enable that software can neither read nor write. Only the core's interrupt-accept strobe and its return-from-interrupt strobe change that internal gate.

Software reaches the flags and enables through a small register port. When an interrupt is taken, the unit closes both global gates and gives the core a one-cycle indication to fetch from the fixed interrupt vector at address 0x004. The return strobe opens both gates again. The unit never stores data on the core's return stack. A separate wake output reports any enabled pending source, with the global gates left out of it, so that an enabled event can bring the core out of sleep.

Top module: `irq_gate`

## Requirements
- R1: After reset all four registers read 0, irqReq, vecFetch and wake are 0, and the internal enable is 1. An enabled pending source therefore raises irqReq without any earlier return strobe.
- R2: The register at address 0 holds the global enable in bit 7, the peripheral group enable in bit 6 and the core source enables in bits [NUM_CORE-1:0]. Address 1 holds the core flags. Address 2 holds the peripheral enables. Address 3 holds the peripheral flags. Unused bits read 0, and rdData is combinational on rdAddr.
- R3: A source event pulse sets that source's flag on the next clock edge, whatever any enable holds. The flag then keeps its value until a write to its flag register replaces it.
- R4: If an event and a flag-register write reach the same source in the same cycle, the flag ends up set, whatever value was written.
- R5: irqReq is 1 exactly when some core source has both its flag and its enable set, or some peripheral source does so while the group enable is set, and in either case the global enable and the internal enable are both 1.
- R6: A peripheral source never raises irqReq or counts as pending while the peripheral group enable is 0.
- R7: A flag that is set while the gates are closed raises irqReq in the first cycle after the gates open. No software action on the flag is needed.
- R8: If irqAccept is high in a cycle where irqReq is high, the global enable and the internal enable both go to 0, and vecFetch is high for exactly the following cycle. The accept wins over a register write to bit 7 in the same cycle.
- R9: If irqAccept is high in a cycle where irqReq is low, it has no effect.
- R10: irqReturn sets the global enable and the internal enable on the next edge. A new request can therefore appear no earlier than the cycle after the return strobe.
- R11: The internal enable is hidden. After an accept, software setting bit 7 again brings back no request until a return strobe arrives, and no register read shows the internal enable.
- R12: wake is 1 whenever any source in either group has its flag and its enable set. The global enable, the group enable and the internal enable have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| coreEvt | input | NUM_CORE | Event pulses from the core-group sources |
| periEvt | input | NUM_PERIPH | Event pulses from the peripheral-group sources |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | DATA_W | Register read data |
| irqAccept | input | 1 | Core accepts the pending interrupt |
| irqReturn | input | 1 | Core executes return-from-interrupt |
| irqReq | output | 1 | Interrupt request to the core |
| vecFetch | output | 1 | One-cycle indication to fetch from the vector at 0x004 |
| wake | output | 1 | An enabled source is pending (wake from sleep) |

## Verification
The bench builds the unit with three core sources and four peripheral sources. With these values the core-enable field does not reach the group-enable bit, so a write of all ones shows that bits 5 to 3 of address 0 read 0. Both groups also hold enough sources for an event on one source and a clear on a neighbouring source to land in the same cycle. Random traffic then mixes accepts, returns and writes to bit 7 around pending flags, and this reaches the cases where the hidden gate and the visible bit disagree.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef struct packed {
    logic gieClr;
    logic gieSet;
  } irqStrobe_t;

  typedef enum logic [1:0] {
    ADDR_CTRL      = 2'd0,
    ADDR_CORE_FLAG = 2'd1,
    ADDR_PERI_EN   = 2'd2,
    ADDR_PERI_FLAG = 2'd3
  } regAddr_t;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               flagWr,
  input  logic               enWr,
  input  logic [NUM_SRC-1:0] wrBits,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] enables,
  output logic               hit
);

  // An event in the same cycle as a write overrides the written value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= (flagWr ? wrBits : flags) | evt;
      if (enWr) enables <= wrBits;
    end
  end

  assign hit = |(flags & enables);

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_chk
      assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
        evt[i] |=> flags[i]);
      assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
        (!evt[i] && !flagWr) |=> $stable(flags[i]));
      assert_evt_beats_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
        (flagWr && evt[i]) |=> flags[i]);
    end
  endgenerate

endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int NUM_CORE   = 3,
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CORE-1:0]   coreEvt,
  input  logic [NUM_PERIPH-1:0] periEvt,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [1:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  irqStrobe_t            strb,
  output logic                  gie,
  output logic                  pendingAny,
  output logic                  wakeAny
);

  localparam int GIE_BIT  = DATA_W - 1;
  localparam int PEIE_BIT = DATA_W - 2;

  logic                  peie;
  logic [NUM_CORE-1:0]   coreFlags, coreEns;
  logic [NUM_PERIPH-1:0] periFlags, periEns;
  logic                  coreHit, periHit;
  logic                  ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  irq_flag_bank #(.NUM_SRC(NUM_CORE)) u_coreBank (
    .clk(clk), .rstN(rstN), .evt(coreEvt),
    .flagWr(wrEn && (wrAddr == ADDR_CORE_FLAG)),
    .enWr(ctrlWr),
    .wrBits(wrData[NUM_CORE-1:0]),
    .flags(coreFlags), .enables(coreEns), .hit(coreHit)
  );

  irq_flag_bank #(.NUM_SRC(NUM_PERIPH)) u_periBank (
    .clk(clk), .rstN(rstN), .evt(periEvt),
    .flagWr(wrEn && (wrAddr == ADDR_PERI_FLAG)),
    .enWr(wrEn && (wrAddr == ADDR_PERI_EN)),
    .wrBits(wrData[NUM_PERIPH-1:0]),
    .flags(periFlags), .enables(periEns), .hit(periHit)
  );

  // Priority on the visible global enable: accept, then return, then software.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gie  <= 1'b0;
      peie <= 1'b0;
    end else begin
      if (strb.gieClr)      gie <= 1'b0;
      else if (strb.gieSet) gie <= 1'b1;
      else if (ctrlWr)      gie <= wrData[GIE_BIT];
      if (ctrlWr) peie <= wrData[PEIE_BIT];
    end
  end

  assign pendingAny = coreHit | (peie & periHit);
  assign wakeAny    = coreHit | periHit;

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_CTRL: begin
        rdData[GIE_BIT]        = gie;
        rdData[PEIE_BIT]       = peie;
        rdData[NUM_CORE-1:0]   = coreEns;
      end
      ADDR_CORE_FLAG: rdData[NUM_CORE-1:0]   = coreFlags;
      ADDR_PERI_EN:   rdData[NUM_PERIPH-1:0] = periEns;
      default:        rdData[NUM_PERIPH-1:0] = periFlags;
    endcase
  end

  assert_accept_clears_gie_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.gieClr |=> !gie);
  assert_return_sets_gie_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.gieSet && !strb.gieClr) |=> gie);
  assert_peri_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!peie && !coreHit) |-> !pendingAny);

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendingAny,
  input  logic       gie,
  input  logic       irqAccept,
  input  logic       irqReturn,
  output irqStrobe_t strb,
  output logic       irqReq,
  output logic       vecFetch
);

  logic intEn;
  logic take;

  assign irqReq = pendingAny & gie & intEn;
  assign take   = irqAccept & irqReq;

  always_comb begin
    strb        = '0;
    strb.gieClr = take;
    strb.gieSet = irqReturn & ~take;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= 1'b1;
      vecFetch <= 1'b0;
    end else begin
      if (take)           intEn <= 1'b0;
      else if (irqReturn) intEn <= 1'b1;
      vecFetch <= take;
    end
  end

  assert_entry_masks_R8: assert property (@(posedge clk) disable iff (!rstN)
    take |=> !irqReq);
  assert_vec_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |-> $past(irqAccept && irqReq));
  assert_vec_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    vecFetch |=> !vecFetch);
  assert_idle_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqAccept && !irqReq && !irqReturn) |=> $stable(intEn));
  assert_return_opens_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReturn && !take) |=> intEn);

endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int NUM_CORE   = 3,
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CORE-1:0]   coreEvt,
  input  logic [NUM_PERIPH-1:0] periEvt,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [1:0]            rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  irqAccept,
  input  logic                  irqReturn,
  output logic                  irqReq,
  output logic                  vecFetch,
  output logic                  wake
);

  irqStrobe_t strb;
  logic       gie, pendingAny, wakeAny;

  irq_gate_dp #(.NUM_CORE(NUM_CORE), .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .coreEvt(coreEvt), .periEvt(periEvt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .strb(strb), .gie(gie), .pendingAny(pendingAny), .wakeAny(wakeAny)
  );

  irq_gate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pendingAny(pendingAny), .gie(gie),
    .irqAccept(irqAccept), .irqReturn(irqReturn),
    .strb(strb), .irqReq(irqReq), .vecFetch(vecFetch)
  );

  assign wake = wakeAny;

  assert_req_implies_wake_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wake);

endmodule

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int NP = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] coreEvt = '0;
  logic [NP-1:0] periEvt = '0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    rdAddr = '0;
  logic [DW-1:0] rdData;
  logic          irqAccept = 1'b0, irqReturn = 1'b0;
  logic          irqReq, vecFetch, wake;

  irq_gate #(.NUM_CORE(NC), .NUM_PERIPH(NP), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .coreEvt(coreEvt), .periEvt(periEvt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irqAccept(irqAccept), .irqReturn(irqReturn),
    .irqReq(irqReq), .vecFetch(vecFetch), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  bit mGie, mPeie, mHidden, mVec;
  bit mCf[NC]; bit mCe[NC]; bit mPf[NP]; bit mPe[NP];

  function automatic bit modelWake();
    bit w = 0;
    for (int i = 0; i < NC; i++) if (mCf[i] && mCe[i]) w = 1;
    for (int i = 0; i < NP; i++) if (mPf[i] && mPe[i]) w = 1;
    return w;
  endfunction

  function automatic bit modelReq();
    bit p = 0;
    for (int i = 0; i < NC; i++) if (mCf[i] && mCe[i]) p = 1;
    if (mPeie) for (int i = 0; i < NP; i++) if (mPf[i] && mPe[i]) p = 1;
    return p && mGie && mHidden;
  endfunction

  function automatic int modelRead(input int a);
    int v = 0;
    case (a)
      0: begin
        v = mGie * 128 + mPeie * 64;
        for (int i = 0; i < NC; i++) if (mCe[i]) v += (1 << i);
      end
      1: for (int i = 0; i < NC; i++) if (mCf[i]) v += (1 << i);
      2: for (int i = 0; i < NP; i++) if (mPe[i]) v += (1 << i);
      default: for (int i = 0; i < NP; i++) if (mPf[i]) v += (1 << i);
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mGie = 0; mPeie = 0; mHidden = 1; mVec = 0;
      for (int i = 0; i < NC; i++) begin mCf[i] = 0; mCe[i] = 0; end
      for (int i = 0; i < NP; i++) begin mPf[i] = 0; mPe[i] = 0; end
    end else begin
      bit acc;
      acc = irqAccept && modelReq();
      mVec = acc;
      for (int i = 0; i < NC; i++) begin
        if (wrEn && wrAddr == 1) mCf[i] = wrData[i];
        if (coreEvt[i]) mCf[i] = 1;
        if (wrEn && wrAddr == 0) mCe[i] = wrData[i];
      end
      for (int i = 0; i < NP; i++) begin
        if (wrEn && wrAddr == 3) mPf[i] = wrData[i];
        if (periEvt[i]) mPf[i] = 1;
        if (wrEn && wrAddr == 2) mPe[i] = wrData[i];
      end
      if (wrEn && wrAddr == 0) mPeie = wrData[6];
      if (acc) begin mGie = 0; mHidden = 0; end
      else if (irqReturn) begin mGie = 1; mHidden = 1; end
      else if (wrEn && wrAddr == 0) mGie = wrData[7];
    end
  end

  task automatic compare(input string tag);
    vectors++;
    if (irqReq !== modelReq()) begin
      miscompares++;
      $display("FAIL %s irqReq actual=%b expected=%b t=%0t", tag, irqReq, modelReq(), $time);
    end
    if (vecFetch !== mVec) begin
      miscompares++;
      $display("FAIL %s vecFetch actual=%b expected=%b t=%0t", tag, vecFetch, mVec, $time);
    end
    if (wake !== modelWake()) begin
      miscompares++;
      $display("FAIL %s wake actual=%b expected=%b t=%0t", tag, wake, modelWake(), $time);
    end
    if (int'(rdData) != modelRead(int'(rdAddr))) begin
      miscompares++;
      $display("FAIL %s rdData[%0d] actual=%0h expected=%0h t=%0t", tag, rdAddr, rdData,
               modelRead(int'(rdAddr)), $time);
    end
  endtask

  task automatic cyc(input string tag, input int ce = 0, input int pe = 0,
                     input bit we = 0, input int wa = 0, input int wd = 0,
                     input int ra = 0, input bit acc = 0, input bit ret = 0);
    @(negedge clk);
    coreEvt = NC'(ce); periEvt = NP'(pe);
    wrEn = we; wrAddr = 2'(wa); wrData = DW'(wd); rdAddr = 2'(ra);
    irqAccept = acc; irqReturn = ret;
    #(CLK_PERIOD/2 - 1);
    if (rstN) compare(tag);
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 4; a++) cyc(tag, 0, 0, 0, 0, 0, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state and hidden enable defaulting to 1
    readAll("R1");
    // R2 register layout, unused bits read zero
    cyc("R2", 0, 0, 1, 0, 'hC5);
    readAll("R2");
    cyc("R2", 0, 0, 1, 0, 'hFF);
    cyc("R2", 0, 0, 1, 2, 'hFF);
    readAll("R2");
    cyc("R2", 0, 0, 1, 0, 'h00);
    cyc("R2", 0, 0, 1, 2, 'h00);
    // R3 sticky flags with everything disabled
    cyc("R3", 1, 'h8, 0, 0, 0, 1);
    repeat (4) cyc("R3", 0, 0, 0, 0, 0, 1);
    cyc("R3", 0, 0, 0, 0, 0, 3);
    cyc("R3", 0, 0, 1, 1, 0, 1);
    cyc("R3", 0, 0, 1, 3, 0, 3);
    // R4 event and clear in the same cycle on the same source and a neighbour
    cyc("R4", 2, 0, 1, 1, 'h6, 1);
    cyc("R4", 0, 0, 0, 0, 0, 1);
    cyc("R4", 0, 4, 1, 3, 0, 3);
    cyc("R4", 0, 0, 1, 3, 0, 3);
    cyc("R4", 0, 0, 1, 1, 0, 1);
    // R1/R5 request with hidden enable at its reset value
    cyc("R5", 1, 0, 0, 0, 0, 1);
    cyc("R5", 0, 0, 1, 0, 'h01);
    cyc("R5", 0, 0, 1, 0, 'h81);
    cyc("R1", 0, 0, 0, 0, 0, 0);
    // R9 accept ignored when no request: disable gie first
    cyc("R9", 0, 0, 1, 0, 'h01);
    cyc("R9", 0, 0, 0, 0, 0, 0, 1);
    cyc("R9", 0, 0, 1, 0, 'h81);
    // R8 accept with simultaneous write of bit 7
    cyc("R8", 0, 0, 1, 0, 'h81, 0, 1);
    cyc("R8", 0, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0);
    // R11 software re-enables visible bit, hidden still closed
    cyc("R11", 0, 0, 1, 0, 'h81);
    repeat (3) cyc("R11", 0, 0, 0, 0, 0, 0);
    // R10 return opens next cycle
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R10", 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 0, 1, 1, 0, 1);
    // R6 peripheral group gate
    cyc("R6", 0, 2, 1, 2, 'h2, 3);
    cyc("R6", 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 0, 'hC0);
    cyc("R6", 0, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 1, 0, 'h80);
    cyc("R6", 0, 0, 1, 3, 0, 3);
    // R7 flag arriving while gates closed, then opened
    cyc("R7", 0, 0, 1, 0, 'h02);
    cyc("R7", 2, 0, 0, 0, 0, 1);
    repeat (3) cyc("R7", 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 1, 0, 'h82);
    cyc("R7", 0, 0, 0, 0, 0, 0);
    cyc("R7", 0, 0, 1, 1, 0, 1);
    // R12 wake independent of global gates
    cyc("R12", 0, 0, 1, 0, 'h04);
    cyc("R12", 4, 0, 0, 0, 0, 1);
    cyc("R12", 0, 0, 1, 1, 0, 1);
    cyc("R12", 0, 0, 1, 0, 'h00);
    // mid-run reset back to R1 state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readAll("R1");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc("random R3-R12 mix",
          ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7) : 0,
          ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : 0,
          r < 15, $urandom_range(0, 3), $urandom_range(0, 255),
          $urandom_range(0, 3), $urandom_range(0, 3) == 0, $urandom_range(0, 19) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule